// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the register front end of a multi-channel DMA engine. A host reaches it over a plain 32-bit memory-mapped bus with one-cycle writes and a combinational read path. Each channel has its own 8 KiB address window. Inside that window, the word index selects one of the channel's control, pointer, interrupt and status registers. Descriptor fetch and the data movers are outside this block. The block sends them single-cycle request pulses: a descriptor load, a channel start and a continue. It takes back from them the end-of-list flag, the stream command source and the interrupt events.

Each channel keeps a one-hot run state: reset (1), stopped (2) or running (4). Writes to the configuration register move this state. A start request moves it to running, but only when a client is attached to that channel. Interrupts work as follows. Events set pending bits. The mask selects which pending bits drive the channel's interrupt line. A write to the acknowledge register clears the pending bits named in the written word, and that register always reads back as zero.

Address decode: the channel number is the address shifted right by 13. The word index is bits 7:2. Word indices: 0 configuration, 1 command, 2 descriptor pointer, 3 buffer pointer, 4 group pointer, 5 group-down pointer, 6 status (read only), 7 stream command, 8 pending interrupts (read only), 9 interrupt mask, 10 acknowledge, 11 masked interrupts (read only).

Top module: `dma_chan_regbank`

## Requirements
- R1: After reset every register of every channel reads zero, and the status word of every channel reads 1 (state reset, no other field set while the flag inputs are low).
- R2: The channel is the address shifted right by 13 and the word index is address bits 7:2. A write reaches only the addressed channel and register, and pointer registers 2 to 5 read back the full 32-bit written value.
- R3: Configuration bit 0 is enable and bit 1 is stop. A configuration write with stop set puts the channel in stopped (2). A configuration write with enable clear puts it in reset (1), and this takes priority over stop. A write with enable set and stop clear keeps the current state.
- R4: The status word (index 6) carries the state in bits 2:0, the channel's end-of-list input at bit 5, and its stream-source input from bit 8 upward. All other bits are zero.
- R5: A stream command write (index 7) stores only the low 10 bits. Bit 3 (load) gives a one-cycle load pulse. If bit 1 (burst) is also set and the channel has a client, the channel enters running (4) and gives a one-cycle start pulse.
- R6: A start request on a channel with no client gives no start pulse and leaves the state unchanged. The load pulse is still issued.
- R7: An event input bit sets the matching pending bit (index 8). The channel interrupt line is high exactly when pending AND mask (index 9) is nonzero, and index 11 reads that product.
- R8: A write to the acknowledge register (index 10) clears every pending bit that is set in the written word, with a new event in the same cycle taking priority. The acknowledge register always reads 0.
- R9: A command write (index 1) with bit 0 set gives a one-cycle continue pulse only when the channel is enabled, not stopped and running. Otherwise there is no pulse.
- R10: An access whose size is not 4 bytes changes nothing on a write and returns zero on a read.
- R11: Accesses to a channel number at or beyond the channel count, or to an unused word index, change nothing and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| client_present | input | NCH | Per channel: a client is attached |
| eol_in | input | NCH | Per channel end-of-list flag from the data mover |
| src_in | input | NCH*SRC_W | Per channel stream command source |
| evt_in | input | NCH*IRQ_W | Per channel interrupt event bits |
| irq | output | NCH | Per channel interrupt line |
| load_pulse | output | NCH | Descriptor load request |
| start_pulse | output | NCH | Channel start request |
| cont_pulse | output | NCH | Continue request |

## Verification
The bound checker checks three things on every cycle: the one-hot legality of each channel's state, that a start pulse never appears without a client and always coincides with the running state, and that reads of the acknowledge register and reads with a bad size return zero. It also checks that a configuration write with enable clear lands the channel in reset. Other behaviour needs the bench's directed scenarios: the priority between stop and enable, the composed status word, the 10-bit truncation of stream commands, the gating of continue by enable, stop and state, the isolation between channels, and the sequence in which pending, mask and acknowledge interact.

// File: rtl/dmacr_pkg.sv
package dmacr_pkg;
  localparam int BUS_W = 32;
  localparam int IDX_W = 6;
  localparam int WIN_SHIFT = 13;

  typedef enum logic [2:0] {
    ST_RST  = 3'b001,
    ST_STOP = 3'b010,
    ST_RUN  = 3'b100
  } chan_state_e;

  localparam logic [IDX_W-1:0] IX_CFG    = 6'd0;
  localparam logic [IDX_W-1:0] IX_CMD    = 6'd1;
  localparam logic [IDX_W-1:0] IX_PDESC  = 6'd2;
  localparam logic [IDX_W-1:0] IX_PBUF   = 6'd3;
  localparam logic [IDX_W-1:0] IX_GRP    = 6'd4;
  localparam logic [IDX_W-1:0] IX_GRPDN  = 6'd5;
  localparam logic [IDX_W-1:0] IX_STAT   = 6'd6;
  localparam logic [IDX_W-1:0] IX_STREAM = 6'd7;
  localparam logic [IDX_W-1:0] IX_PEND   = 6'd8;
  localparam logic [IDX_W-1:0] IX_MASK   = 6'd9;
  localparam logic [IDX_W-1:0] IX_ACK    = 6'd10;
  localparam logic [IDX_W-1:0] IX_MASKED = 6'd11;

  localparam int SCMD_W     = 10;
  localparam int SCMD_BURST = 1;
  localparam int SCMD_LOAD  = 3;

  // Stop forces stopped; a cleared enable is applied afterwards and wins.
  function automatic chan_state_e cfg_next(chan_state_e cur, logic [1:0] cfg_bits);
    chan_state_e nxt;
    nxt = cur;
    if (cfg_bits[1]) nxt = ST_STOP;
    if (!cfg_bits[0]) nxt = ST_RST;
    return nxt;
  endfunction
endpackage

// File: rtl/dmacr_chan.sv
module dmacr_chan
  import dmacr_pkg::*;
#(
  parameter int IRQ_W = 4,
  parameter int SRC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             client_ok,
  input  logic             eol_in,
  input  logic [SRC_W-1:0] src_in,
  input  logic [IRQ_W-1:0] evt_in,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [BUS_W-1:0] rd_data,
  output logic             irq,
  output logic             start_pulse,
  output logic             load_pulse,
  output logic             cont_pulse,
  output logic [2:0]       state_o
);
  localparam int STAT_PAD = BUS_W - 8 - SRC_W;

  chan_state_e       state;
  logic [BUS_W-1:0]  cfg_r, cmd_r, pdesc_r, pbuf_r, grp_r, grpdn_r;
  logic [SCMD_W-1:0] scmd_r;
  logic [IRQ_W-1:0]  mask_r, pend_r, ack_clr, masked;
  logic              go_req;

  assign ack_clr = (wr_en && wr_idx == IX_ACK) ? wr_data[IRQ_W-1:0] : '0;
  assign masked  = pend_r & mask_r;
  assign irq     = |masked;
  assign state_o = state;
  assign go_req  = wr_data[SCMD_LOAD] && wr_data[SCMD_BURST];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_RST;
      cfg_r       <= '0;
      cmd_r       <= '0;
      pdesc_r     <= '0;
      pbuf_r      <= '0;
      grp_r       <= '0;
      grpdn_r     <= '0;
      scmd_r      <= '0;
      mask_r      <= '0;
      pend_r      <= '0;
      start_pulse <= 1'b0;
      load_pulse  <= 1'b0;
      cont_pulse  <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      load_pulse  <= 1'b0;
      cont_pulse  <= 1'b0;
      pend_r      <= (pend_r & ~ack_clr) | evt_in;
      if (wr_en) begin
        unique case (wr_idx)
          IX_CFG: begin
            cfg_r <= wr_data;
            state <= cfg_next(state, wr_data[1:0]);
          end
          IX_CMD: begin
            cmd_r <= wr_data;
            if (wr_data[0] && cfg_r[0] && !cfg_r[1] && state == ST_RUN)
              cont_pulse <= 1'b1;
          end
          IX_PDESC: pdesc_r <= wr_data;
          IX_PBUF:  pbuf_r  <= wr_data;
          IX_GRP:   grp_r   <= wr_data;
          IX_GRPDN: grpdn_r <= wr_data;
          IX_STREAM: begin
            scmd_r <= wr_data[SCMD_W-1:0];
            if (wr_data[SCMD_LOAD]) load_pulse <= 1'b1;
            if (go_req && client_ok) begin
              state       <= ST_RUN;
              start_pulse <= 1'b1;
            end
          end
          IX_MASK: mask_r <= wr_data[IRQ_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_idx)
      IX_CFG:    rd_data = cfg_r;
      IX_CMD:    rd_data = cmd_r;
      IX_PDESC:  rd_data = pdesc_r;
      IX_PBUF:   rd_data = pbuf_r;
      IX_GRP:    rd_data = grp_r;
      IX_GRPDN:  rd_data = grpdn_r;
      IX_STAT:   rd_data = {{STAT_PAD{1'b0}}, src_in, 2'b00, eol_in, 2'b00, state};
      IX_STREAM: rd_data = {{(BUS_W-SCMD_W){1'b0}}, scmd_r};
      IX_PEND:   rd_data = {{(BUS_W-IRQ_W){1'b0}}, pend_r};
      IX_MASK:   rd_data = {{(BUS_W-IRQ_W){1'b0}}, mask_r};
      IX_MASKED: rd_data = {{(BUS_W-IRQ_W){1'b0}}, masked};
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dmacr_rdmux.sv
module dmacr_rdmux
  import dmacr_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 2
) (
  input  logic [NCH*BUS_W-1:0] all_data,
  input  logic [CW-1:0]        sel,
  input  logic                 enable,
  output logic [BUS_W-1:0]     dout
);
  always_comb begin
    dout = '0;
    for (int c = 0; c < NCH; c++) begin
      if (enable && sel == CW'(c)) dout = all_data[c*BUS_W +: BUS_W];
    end
  end
endmodule

// File: rtl/dma_chan_regbank.sv
module dma_chan_regbank
  import dmacr_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 16,
  parameter int IRQ_W  = 4,
  parameter int SRC_W  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [2:0]             bus_size,
  input  logic [BUS_W-1:0]       bus_wdata,
  output logic [BUS_W-1:0]       bus_rdata,
  input  logic [NCH-1:0]         client_present,
  input  logic [NCH-1:0]         eol_in,
  input  logic [NCH*SRC_W-1:0]   src_in,
  input  logic [NCH*IRQ_W-1:0]   evt_in,
  output logic [NCH-1:0]         irq,
  output logic [NCH-1:0]         load_pulse,
  output logic [NCH-1:0]         start_pulse,
  output logic [NCH-1:0]         cont_pulse
);
  localparam int CH_F_W = ADDR_W - WIN_SHIFT;
  localparam int CW     = (NCH > 1) ? $clog2(NCH) : 1;

  logic [CH_F_W-1:0]    ch_field;
  logic [IDX_W-1:0]     idx;
  logic                 ch_hit, size_ok, wr_go, rd_go;
  logic [NCH*BUS_W-1:0] all_rd;
  logic [NCH*3-1:0]     st_flat;
  logic [6:0]           unused_addr;

  assign ch_field    = bus_addr[ADDR_W-1:WIN_SHIFT];
  assign idx         = bus_addr[7:2];
  assign unused_addr = {bus_addr[WIN_SHIFT-1:8], bus_addr[1:0]};
  assign ch_hit      = ch_field < CH_F_W'(NCH);
  assign size_ok     = bus_size == 3'd4;
  assign wr_go       = bus_sel && bus_we && size_ok && ch_hit;
  assign rd_go       = bus_sel && !bus_we && size_ok && ch_hit;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dmacr_chan #(.IRQ_W(IRQ_W), .SRC_W(SRC_W)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_go && ch_field == CH_F_W'(c)),
      .wr_idx      (idx),
      .wr_data     (bus_wdata),
      .client_ok   (client_present[c]),
      .eol_in      (eol_in[c]),
      .src_in      (src_in[c*SRC_W +: SRC_W]),
      .evt_in      (evt_in[c*IRQ_W +: IRQ_W]),
      .rd_idx      (idx),
      .rd_data     (all_rd[c*BUS_W +: BUS_W]),
      .irq         (irq[c]),
      .start_pulse (start_pulse[c]),
      .load_pulse  (load_pulse[c]),
      .cont_pulse  (cont_pulse[c]),
      .state_o     (st_flat[c*3 +: 3])
    );
  end

  dmacr_rdmux #(.NCH(NCH), .CW(CW)) u_rdmux (
    .all_data (all_rd),
    .sel      (ch_field[CW-1:0]),
    .enable   (rd_go),
    .dout     (bus_rdata)
  );
endmodule

// File: rtl/dmacr_chk.sv
module dmacr_chk #(
  parameter int NCH    = 4,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [2:0]        bus_size,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [NCH-1:0]    client_present,
  input logic [NCH-1:0]    start_pulse,
  input logic [NCH*3-1:0]  st_flat
);
  // R8
  ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr[7:2] == 6'd10) |-> bus_rdata == 32'd0);

  // R10
  bad_size_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_size != 3'd4) |-> bus_rdata == 32'd0);

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R3
    state_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(st_flat[c*3 +: 3]));

    // R6
    start_needs_client_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse[c] |-> $past(client_present[c]));

    // R5
    start_means_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse[c] |-> st_flat[c*3 +: 3] == 3'b100);

    // R3
    disable_to_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && bus_size == 3'd4 && bus_addr[7:2] == 6'd0 &&
       (bus_addr >> 13) == ADDR_W'(c) && !bus_wdata[0])
      |=> st_flat[c*3 +: 3] == 3'b001);
  end
endmodule

bind dma_chan_regbank dmacr_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_sel        (bus_sel),
  .bus_we         (bus_we),
  .bus_addr       (bus_addr),
  .bus_size       (bus_size),
  .bus_wdata      (bus_wdata),
  .bus_rdata      (bus_rdata),
  .client_present (client_present),
  .start_pulse    (start_pulse),
  .st_flat        (st_flat)
);

// File: tb/dma_chan_regbank_test.sv
module dma_chan_regbank_test;
  localparam int NCH = 4, ADDR_W = 16, IRQ_W = 4, SRC_W = 2;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [2:0] bus_size = 3'd4;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] client_present = '0, eol_in = '0;
  logic [NCH*SRC_W-1:0] src_in = '0;
  logic [NCH*IRQ_W-1:0] evt_in = '0;
  logic [NCH-1:0] irq, load_pulse, start_pulse, cont_pulse;
  logic [NCH-1:0] cap_load, cap_start, cap_cont;
  int errors = 0, checks = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  dma_chan_regbank #(.NCH(NCH), .ADDR_W(ADDR_W), .IRQ_W(IRQ_W), .SRC_W(SRC_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .client_present(client_present), .eol_in(eol_in), .src_in(src_in), .evt_in(evt_in),
    .irq(irq), .load_pulse(load_pulse), .start_pulse(start_pulse), .cont_pulse(cont_pulse));

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(int ch, int ix);
    return ADDR_W'((ch << 13) | (ix << 2));
  endfunction

  task automatic wr(int ch, int ix, logic [31:0] d, logic [2:0] sz = 3'd4);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = mk(ch, ix); bus_wdata = d; bus_size = sz;
    @(posedge clk); #1;
    cap_load = load_pulse; cap_start = start_pulse; cap_cont = cont_pulse;
    bus_sel = 0; bus_we = 0; bus_size = 3'd4;
  endtask

  task automatic rd(int ch, int ix, output logic [31:0] d, input logic [2:0] sz = 3'd4);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = mk(ch, ix); bus_size = sz;
    #1 d = bus_rdata;
    bus_sel = 0; bus_size = 3'd4;
  endtask

  task automatic t_reset();
    for (int c = 0; c < NCH; c++) begin
      rd(c, 6, rv); check("R1 status", rv, 32'h1);
      rd(c, 0, rv); check("R1 cfg", rv, 32'h0);
      rd(c, 8, rv); check("R1 pend", rv, 32'h0);
    end
    check("R1 irq", {28'd0, irq}, 32'h0);
  endtask

  task automatic t_decode();
    wr(3, 2, 32'hDEADBEEF);
    rd(3, 2, rv); check("R2 ptr ch3", rv, 32'hDEADBEEF);
    rd(0, 2, rv); check("R2 ptr ch0 untouched", rv, 32'h0);
    wr(2, 5, 32'h12345678);
    rd(2, 5, rv); check("R2 grpdn ch2", rv, 32'h12345678);
    rd(2, 4, rv); check("R2 grp ch2 untouched", rv, 32'h0);
  endtask

  task automatic t_cfg_state();
    client_present[1] = 1;
    wr(1, 0, 32'h1);
    rd(1, 6, rv); check("R3 enable keeps reset", rv, 32'h1);
    wr(1, 7, 32'h00A);
    check("R5 start pulse", {31'd0, cap_start[1]}, 32'h1);
    check("R5 load pulse", {31'd0, cap_load[1]}, 32'h1);
    rd(1, 6, rv); check("R5 running", rv, 32'h4);
    @(posedge clk); #1 check("R5 start one cycle", {31'd0, start_pulse[1]}, 32'h0);
    wr(1, 0, 32'h3);
    rd(1, 6, rv); check("R3 stop", rv, 32'h2);
    wr(1, 0, 32'h2);
    rd(1, 6, rv); check("R3 enable clear wins", rv, 32'h1);
  endtask

  task automatic t_status();
    eol_in[2] = 1; src_in[2*SRC_W +: SRC_W] = 2'd3;
    rd(2, 6, rv); check("R4 status compose", rv, 32'h321);
    eol_in[2] = 0; src_in = '0;
  endtask

  task automatic t_stream();
    client_present[3] = 1;
    wr(3, 7, 32'hFFFF_F3F5);
    rd(3, 7, rv); check("R5 10 bits kept", rv, 32'h3F5);
    check("R5 no load bit no pulse", {31'd0, cap_load[3]}, 32'h0);
    client_present[0] = 0;
    wr(0, 7, 32'h00A);
    check("R6 load without client", {31'd0, cap_load[0]}, 32'h1);
    check("R6 no start without client", {31'd0, cap_start[0]}, 32'h0);
    rd(0, 6, rv); check("R6 state unchanged", rv, 32'h1);
  endtask

  task automatic t_irq();
    @(negedge clk); evt_in[1*IRQ_W +: IRQ_W] = 4'b0101;
    @(negedge clk); evt_in = '0;
    rd(1, 8, rv); check("R7 pending set", rv, 32'h5);
    check("R7 masked off irq low", {31'd0, irq[1]}, 32'h0);
    wr(1, 9, 32'h4);
    rd(1, 9, rv); check("R7 mask readback", rv, 32'h4);
    rd(1, 11, rv); check("R7 masked", rv, 32'h4);
    check("R7 irq high", {31'd0, irq[1]}, 32'h1);
    wr(1, 10, 32'h4);
    rd(1, 8, rv); check("R8 ack clears", rv, 32'h1);
    check("R8 irq low after ack", {31'd0, irq[1]}, 32'h0);
    rd(1, 10, rv); check("R8 ack reads zero", rv, 32'h0);
  endtask

  task automatic t_cont();
    wr(1, 0, 32'h1);
    wr(1, 7, 32'h00A);
    wr(1, 1, 32'h1);
    check("R9 continue when running", {31'd0, cap_cont[1]}, 32'h1);
    wr(1, 0, 32'h3);
    wr(1, 1, 32'h1);
    check("R9 no continue when stopped", {31'd0, cap_cont[1]}, 32'h0);
    wr(2, 1, 32'h1);
    check("R9 no continue in reset", {31'd0, cap_cont[2]}, 32'h0);
  endtask

  task automatic t_size_range();
    wr(0, 3, 32'hCAFE0000, 3'd2);
    rd(0, 3, rv); check("R10 short write ignored", rv, 32'h0);
    wr(0, 3, 32'h0000BEEF);
    rd(0, 3, rv, 3'd1); check("R10 short read zero", rv, 32'h0);
    wr(0, 20, 32'hFFFFFFFF);
    rd(0, 20, rv); check("R11 unused index", rv, 32'h0);
    wr(5, 2, 32'h55AA55AA);
    rd(5, 2, rv); check("R11 channel out of range", rv, 32'h0);
    rd(1, 2, rv); check("R11 no alias", rv, 32'h0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        t_reset();
        t_decode();
        t_cfg_state();
        t_status();
        t_stream();
        t_irq();
        t_cont();
        t_size_range();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule